// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART output line on every tick of a 16x-baud sample enable. Each bit cell in which the line is low becomes a single high pulse on the IR output. Each cell in which the line is high leaves the IR output low for the whole cell. The pulse width is chosen by a 3-bit code. Code 000 gives 3/16 of a bit. Every other code gives a fixed count of system clocks, so that a width of about 1.6 µs can be reached at several clock rates. No selectable width may fall below 1.41 µs or exceed the upper limit on pulse width.

On the receive side the raw IR line passes through a two-flop synchronizer. The rising edge of each incoming pulse pulls the reconstructed UART receive line low for one bit time, which is 16 ticks. A cell with no pulse therefore reads as 1. When the enable input is clear, both directions pass their line straight through, and every pulse and stretch counter is held cleared. UART framing, baud generation and the analog front end are not part of this block.

Top module: `irda_sir_codec`

## Requirements
- R1: With enable set, a tick on which `uart_txd` is sampled low at a cell boundary starts one pulse. `ir_txd` goes high in the clock cycle after that tick edge, and only one rising edge occurs within the 16-tick cell.
- R2: With enable set, a cell whose boundary tick samples `uart_txd` high produces no pulse, and `ir_txd` stays low for all 16 ticks.
- R3: After reset `ir_txd` is 0 and `uart_rxd` is 1. Width code 000 makes the pulse last exactly 3 tick periods, which is 3/16 of a bit.
- R4: A width code c from 1 to 7 makes the pulse last exactly 8*(c+1) system clocks (16, 24, ... 64).
- R5: Consecutive low cells each produce their own pulse, and the pulses start 16 ticks apart.
- R6: A rising edge on `ir_rxd_raw` drives `uart_rxd` low from the third rising clock edge after the raw line rises. This is the latency of the two synchronizer flops plus the edge register.
- R7: Once pulled low, `uart_rxd` returns high on the 16th tick after the edge was registered, whatever the width of the incoming pulse.
- R8: With enable clear, `ir_txd` equals `uart_txd` and `uart_rxd` equals `ir_rxd_raw` combinationally. Both counters are cleared, so a stretch in progress does not resume when enable is set again.
- R9: A new receive edge during a stretch restarts the 16-tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| enable | input | 1 | 1 = encode/decode, 0 = pass-through |
| width_sel | input | 3 | Transmit pulse width code |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_rxd_raw | input | 1 | Unsynchronized IR receiver output, high = pulse |
| ir_txd | output | 1 | IR emitter drive, high = light |
| uart_rxd | output | 1 | Reconstructed serial data for the UART receiver |

## Verification
The hardest situation to reach is a receive edge that arrives on different clock phases relative to the tick. The length of the stretch in clocks depends on where the edge lands between ticks, and it must still end on the 16th tick. The bench sweeps the arrival phase over every clock slot of the tick period and several pulse widths. It also places a second pulse inside a running stretch, and drops enable in the middle of a stretch, comparing against a cycle model built from the requirements. On the transmit side every width code is crossed with data bytes that contain runs of zeros. This covers back-to-back pulses and the longest clock-counted pulse near the end of its cell.

// File: rtl/irda_pkg.sv
package irda_pkg;

  // Ticks of the 16x enable in one bit cell.
  localparam int CELL_TICKS = 16;

  // Code 0 selects a tick-counted width; other codes count system clocks.
  function automatic logic width_in_ticks(input int code);
    return (code == 0);
  endfunction

  // Load value for the transmit pulse counter.
  function automatic int pulse_load(input int code, input int tick_width, input int clk_unit);
    if (code == 0) return tick_width;
    return clk_unit * (code + 1);
  endfunction

endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irda_tx_pulse.sv
module irda_tx_pulse #(
  parameter int CELL_TICKS = 16,
  parameter int TICK_WIDTH = 3,
  parameter int CLK_UNIT   = 8,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick16,
  input  logic [SEL_W-1:0] width_sel,
  input  logic             uart_txd,
  output logic             cell_start,
  output logic             pulse_on
);
  localparam int PH_W  = $clog2(CELL_TICKS);
  localparam int MAXW  = CLK_UNIT * (2 ** SEL_W);
  localparam int CNT_W = $clog2(MAXW + 1);

  logic             in_cell;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] pcnt;
  logic             by_ticks;
  logic             boundary;

  assign boundary   = tick16 && (!in_cell || phase == PH_W'(CELL_TICKS - 1));
  assign cell_start = enable && boundary && !uart_txd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell  <= 1'b0;
      phase    <= '0;
      pcnt     <= '0;
      by_ticks <= 1'b0;
    end else if (!enable) begin
      in_cell  <= 1'b0;
      phase    <= '0;
      pcnt     <= '0;
      by_ticks <= 1'b0;
    end else begin
      if (tick16) begin
        if (boundary) begin
          in_cell <= !uart_txd;
          phase   <= '0;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (cell_start) begin
        by_ticks <= irda_pkg::width_in_ticks(int'(width_sel));
        pcnt     <= CNT_W'(irda_pkg::pulse_load(int'(width_sel), TICK_WIDTH, CLK_UNIT));
      end else if (pcnt != '0 && (!by_ticks || tick16)) begin
        pcnt <= pcnt - 1'b1;
      end
    end
  end

  assign pulse_on = (pcnt != '0);
endmodule

// File: rtl/irda_rx_stretch.sv
module irda_rx_stretch #(
  parameter int CELL_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick16,
  input  logic rx_sync,
  output logic rx_edge,
  output logic stretch_on
);
  localparam int SC_W = $clog2(CELL_TICKS + 1);

  logic            prev;
  logic [SC_W-1:0] scnt;

  assign rx_edge = enable && rx_sync && !prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= rx_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      scnt <= '0;
    else if (!enable)                scnt <= '0;
    else if (rx_edge)                scnt <= SC_W'(CELL_TICKS);
    else if (tick16 && scnt != '0)   scnt <= scnt - 1'b1;
  end

  assign stretch_on = (scnt != '0);
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
  parameter int TICK_WIDTH  = 3,
  parameter int CLK_UNIT    = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             enable,
  input  logic [SEL_W-1:0] width_sel,
  input  logic             uart_txd,
  input  logic             ir_rxd_raw,
  output logic             ir_txd,
  output logic             uart_rxd
);
  logic tx_cell_start;
  logic pulse_on;
  logic rx_sync;
  logic rx_edge;
  logic stretch_on;

  irda_tx_pulse #(
    .CELL_TICKS(irda_pkg::CELL_TICKS),
    .TICK_WIDTH(TICK_WIDTH),
    .CLK_UNIT  (CLK_UNIT),
    .SEL_W     (SEL_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick16    (tick16),
    .width_sel (width_sel),
    .uart_txd  (uart_txd),
    .cell_start(tx_cell_start),
    .pulse_on  (pulse_on)
  );

  irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ir_rxd_raw),
    .q    (rx_sync)
  );

  irda_rx_stretch #(.CELL_TICKS(irda_pkg::CELL_TICKS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick16    (tick16),
    .rx_sync   (rx_sync),
    .rx_edge   (rx_edge),
    .stretch_on(stretch_on)
  );

  assign ir_txd   = enable ? pulse_on    : uart_txd;
  assign uart_rxd = enable ? !stretch_on : ir_rxd_raw;
endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic enable,
  input logic uart_txd,
  input logic ir_rxd_raw,
  input logic ir_txd,
  input logic uart_rxd,
  input logic tx_cell_start,
  input logic rx_edge
);
  p_start_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_start |-> (tick16 && !uart_txd && enable));

  p_pulse_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cell_start && enable) |=> (!enable || ir_txd));

  p_rise_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $rose(ir_txd)) |-> $past(tx_cell_start));

  p_sync_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_edge |-> $past(ir_rxd_raw, 2));

  p_stretch_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_edge |=> (!enable || !uart_rxd));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (ir_txd == uart_txd && uart_rxd == ir_rxd_raw));
endmodule

bind irda_sir_codec irda_sir_codec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick16       (tick16),
  .enable       (enable),
  .uart_txd     (uart_txd),
  .ir_rxd_raw   (ir_rxd_raw),
  .ir_txd       (ir_txd),
  .uart_rxd     (uart_rxd),
  .tx_cell_start(tx_cell_start),
  .rx_edge      (rx_edge)
);

// File: tb/irda_sir_codec_bench.sv
`timescale 1ns/1ps
module irda_sir_codec_bench;
  localparam int TDIV = 6;          // clocks per tick
  localparam int CELL = 16 * TDIV;  // clocks per bit cell

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       enable = 1'b1;
  logic [2:0] width_sel = 3'd0;
  logic       uart_txd = 1'b1;
  logic       ir_rxd_raw = 1'b0;
  logic       ir_txd;
  logic       uart_rxd;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic last_tick = 1'b0;
  int   mcnt = 0;         // expected stretch ticks left
  logic [2:0] rh = '0;    // raw at previous posedges

  always #2.5 clk = ~clk;

  irda_sir_codec u_irda_sir_codec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .enable(enable),
    .width_sel(width_sel), .uart_txd(uart_txd), .ir_rxd_raw(ir_rxd_raw),
    .ir_txd(ir_txd), .uart_rxd(uart_rxd)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One clock: advance the receive model past the posedge, then set the next tick.
  task automatic step();
    logic load;
    @(negedge clk);
    last_tick = tick16;
    load = enable && rh[1] && !rh[2];
    if (!rst_n)          begin mcnt = 0; rh = '0; end
    else begin
      if (!enable)       mcnt = 0;
      else if (load)     mcnt = 16;
      else if (last_tick && mcnt > 0) mcnt--;
      rh = {rh[1:0], ir_rxd_raw};
    end
    cyc++;
    tick16 = (cyc % TDIV == 0);
  endtask

  task automatic rx_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step();
      begin
        logic exp;
        exp = enable ? (mcnt == 0) : ir_rxd_raw;
        chk(uart_rxd == exp, tag, uart_rxd, exp);
      end
    end
  endtask

  task automatic align();
    while (tick16 !== 1'b1) step();
  endtask

  // Send one cell; tick16 is high so the next posedge is the boundary tick.
  task automatic send_cell(input logic b, input logic prev_zero);
    int highs = 0, rises = 0, first = -1;
    logic pv = 1'b0;
    int w;
    w = (width_sel == 0) ? 3 * TDIV : 8 * (int'(width_sel) + 1);
    uart_txd = b;
    for (int k = 1; k <= CELL; k++) begin
      step();
      if (ir_txd) begin
        highs++;
        if (first < 0) first = k;
      end
      if (ir_txd && !pv) rises++;
      pv = ir_txd;
    end
    if (b) begin
      chk(highs == 0, "R2 no pulse for one", highs, 0);
    end else begin
      chk(rises == 1, prev_zero ? "R5 one pulse per zero cell" : "R1 one pulse", rises, 1);
      chk(first == 1, "R1 pulse start cycle", first, 1);
      chk(highs == w, (width_sel == 0) ? "R3 tick width" : "R4 clock width", highs, w);
    end
  endtask

  task automatic send_frame(input logic [7:0] d);
    logic [9:0] bits;
    logic pz;
    bits = {1'b1, d, 1'b0};
    pz = 1'b0;
    for (int i = 0; i < 10; i++) begin
      send_cell(bits[i], pz);
      pz = !bits[i];
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #900000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    for (int i = 0; i < 4; i++) step();
    rst_n = 1'b1;
    step();
    chk(ir_txd == 1'b0, "R3 reset ir_txd", ir_txd, 0);
    chk(uart_rxd == 1'b1, "R3 reset uart_rxd", uart_rxd, 1);

    // Transmit sweep over every width code and several bytes.
    for (int s = 0; s < 8; s++) begin
      width_sel = 3'(s);
      for (int p = 0; p < 4; p++) begin
        align();
        send_cell(1'b1, 1'b0);   // idle cell
        send_frame(pats[p]);
      end
    end

    // Receive: every arrival phase against the tick, several pulse widths.
    for (int ph = 0; ph < TDIV; ph++) begin
      for (int li = 0; li < 3; li++) begin
        int len;
        len = (li == 0) ? 4 : (li == 1) ? 10 : 16;
        align();
        for (int j = 0; j < ph; j++) step();
        ir_rxd_raw = 1'b1;
        rx_run(3, "R6 sync latency");
        rx_run(len - 3, "R7 stretch");
        ir_rxd_raw = 1'b0;
        rx_run(CELL + 20, "R7 stretch end");
      end
    end

    // Retrigger within a running stretch.
    ir_rxd_raw = 1'b1; rx_run(8, "R9 first edge");
    ir_rxd_raw = 1'b0; rx_run(40, "R9 before retrigger");
    ir_rxd_raw = 1'b1; rx_run(8, "R9 retrigger");
    ir_rxd_raw = 1'b0; rx_run(CELL + 20, "R9 after retrigger");

    // Pass-through when disabled, and counters cleared.
    ir_rxd_raw = 1'b1; rx_run(6, "R7 pre-disable");
    ir_rxd_raw = 1'b0; rx_run(10, "R7 pre-disable");
    enable = 1'b0;
    for (int v = 0; v < 4; v++) begin
      uart_txd = v[0];
      ir_rxd_raw = v[1];
      #1;
      chk(ir_txd == uart_txd, "R8 tx bypass", ir_txd, uart_txd);
      chk(uart_rxd == ir_rxd_raw, "R8 rx bypass", uart_rxd, ir_rxd_raw);
      rx_run(2, "R8 rx bypass");
    end
    uart_txd = 1'b1;
    ir_rxd_raw = 1'b0;
    rx_run(4, "R8 bypass");
    enable = 1'b1;
    rx_run(CELL, "R8 stretch cleared");
    chk(ir_txd == 1'b0, "R8 tx counter cleared", ir_txd, 0);

    finish_run();
  end
endmodule